// File: doc/BRIEF.md
# Chained DMA Channel Controller

This block is the control plane of one DMA channel in a network interface. It keeps a control/status word and six 32-bit pointer registers: the current buffer (base and limit), the extent of the last finished buffer (saved base and saved limit) and a preloaded next buffer (chain base and chain limit). Software reaches all of them over a word-wide register bus with a single-cycle write strobe and a combinational read port.

Software starts, arms and resets the channel by writing one-shot command bits into the control word. The data mover beside the block pulses `xfer_done` with a byte count when it finishes a receive buffer. If the channel is enabled, the block does several things on that pulse:

- It records where the finished buffer started and where it ended. The end is the start plus the byte count, rounded up to the alignment granule.
- If continuation is armed, it swaps in the chain buffer and disarms continuation.
- It sets the complete flag, which drives a level interrupt request.

Top module: `dma_chain_ctrl`

## Requirements
- R1: After reset every register reads as zero and `irq` is low.
- R2: The word addresses are 1 base, 2 limit, 3 saved base, 4 saved limit, 5 chain base and 6 chain limit. A bus write stores the full word at that address and is accepted whether or not the channel is enabled. Address 7 reads as zero, and reads change no state.
- R3: Address 0 is the control word. On read it returns enable in bit 24, continuation-armed in bit 25 and complete in bit 27, with every other bit zero. Writing bit 16 sets enable, and writing bit 17 sets continuation-armed.
- R4: Writing bit 20 of the control word clears enable, continuation-armed and complete together. This takes priority over every other command and over a completion in the same cycle.
- R5: Writing bit 19 clears complete, unless a completion occurs in the same cycle, in which case complete stays set. Writing bit 18 (device-to-memory direction) alone changes no state.
- R6: An `xfer_done` pulse while enable is clear changes no register and does not raise `irq`.
- R7: On an accepted completion, saved base takes the current base. Saved limit takes base plus `xfer_len` rounded up to the next multiple of 32, modulo 2^32. A length that is already a multiple of 32, including 0, is used unchanged.
- R8: If continuation is armed at an accepted completion, base takes chain base, limit takes chain limit, and continuation-armed clears unless bit 17 is written in that same cycle. If continuation is not armed, base and limit keep their values.
- R9: An accepted completion sets complete. `irq` is high exactly while complete is set and drops only after a clear-complete or reset command.
- R10: When a completion updates a pointer register, that update overrides a bus write to the same register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register bus select |
| bus_we | input | 1 | Write qualifier; with bus_sel, stores bus_wdata on this clock edge |
| bus_addr | input | ADDR_W (3) | Word address of the register |
| bus_wdata | input | DATA_W (32) | Write data or command bits |
| bus_rdata | output | DATA_W (32) | Combinational read data for bus_addr |
| xfer_done | input | 1 | One-cycle pulse: a receive buffer has finished |
| xfer_len | input | LEN_W (16) | Bytes moved in the finished buffer, valid with xfer_done |
| irq | output | 1 | Level interrupt request, high while complete is set |

## Verification
The assertions assume that `xfer_done` is a single-cycle strobe, with `xfer_len` valid in that cycle. They also assume that a command write and a completion may coincide, with the priority rules above deciding the result. The random stimulus issues command words with arbitrary mixes of bits 16 to 20, plus noise in other bit positions. It issues pointer writes to every address and completions of arbitrary length, often in the same cycle as a bus write. Reset commands are drawn rarely, so that chains of completions with and without continuation build up between them.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;

   // control word: status bit positions
   localparam int ST_EN_BIT   = 24;
   localparam int ST_CONT_BIT = 25;
   localparam int ST_DONE_BIT = 27;

   // control word: one-shot command bit positions
   localparam int CMD_EN_BIT   = 16;
   localparam int CMD_CONT_BIT = 17;
   localparam int CMD_DIR_BIT  = 18;
   localparam int CMD_CLR_BIT  = 19;
   localparam int CMD_RST_BIT  = 20;
   localparam int CMD_W        = CMD_RST_BIT - CMD_EN_BIT + 1;

   // pointer register file slots; bus address = slot + 1
   localparam int PI_BASE   = 0;
   localparam int PI_LIMIT  = 1;
   localparam int PI_SBASE  = 2;
   localparam int PI_SLIMIT = 3;
   localparam int PI_CBASE  = 4;
   localparam int PI_CLIMIT = 5;
   localparam int NPTR      = 6;

   localparam int REG_CTRL  = 0;

   typedef struct packed {
      logic reset;
      logic clr_done;
      logic dir;
      logic set_cont;
      logic set_en;
   } cmd_t;

endpackage

// File: rtl/dma_chain_decode.sv
module dma_chain_decode
   import dma_chain_pkg::*;
#(
   parameter int ADDR_W = 3
) (
   input  logic                    bus_sel,
   input  logic                    bus_we,
   input  logic [ADDR_W-1:0]       bus_addr,
   input  logic [CMD_W-1:0]        cmd_bits,
   output cmd_t                    cmd,
   output logic [NPTR-1:0]         ptr_we
);

   logic wr;
   logic ctrl_hit;

   assign wr       = bus_sel && bus_we;
   assign ctrl_hit = wr && (bus_addr == ADDR_W'(REG_CTRL));

   always_comb begin
      cmd.set_en   = ctrl_hit && cmd_bits[CMD_EN_BIT   - CMD_EN_BIT];
      cmd.set_cont = ctrl_hit && cmd_bits[CMD_CONT_BIT - CMD_EN_BIT];
      cmd.dir      = ctrl_hit && cmd_bits[CMD_DIR_BIT  - CMD_EN_BIT];
      cmd.clr_done = ctrl_hit && cmd_bits[CMD_CLR_BIT  - CMD_EN_BIT];
      cmd.reset    = ctrl_hit && cmd_bits[CMD_RST_BIT  - CMD_EN_BIT];
   end

   for (genvar i = 0; i < NPTR; i++) begin : g_ptr_we
      assign ptr_we[i] = wr && (bus_addr == ADDR_W'(i + 1));
   end

endmodule

// File: rtl/dma_chain_csr.sv
module dma_chain_csr
   import dma_chain_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  cmd_t cmd,
   input  logic xfer_done,
   output logic st_en,
   output logic st_cont,
   output logic st_done,
   output logic done_ok,
   output logic reload
);

   logic en_n, cont_n, done_n;

   assign done_ok = xfer_done && st_en;
   assign reload  = done_ok && st_cont;

   always_comb begin
      // enable
      if (cmd.reset)       en_n = 1'b0;
      else if (cmd.set_en) en_n = 1'b1;
      else                 en_n = st_en;
      // continuation: re-arm beats disarm by reload
      if (cmd.reset)         cont_n = 1'b0;
      else if (cmd.set_cont) cont_n = 1'b1;
      else if (reload)       cont_n = 1'b0;
      else                   cont_n = st_cont;
      // complete: new completion beats clear-complete
      if (cmd.reset)         done_n = 1'b0;
      else if (done_ok)      done_n = 1'b1;
      else if (cmd.clr_done) done_n = 1'b0;
      else                   done_n = st_done;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_en   <= 1'b0;
         st_cont <= 1'b0;
         st_done <= 1'b0;
      end else begin
         st_en   <= en_n;
         st_cont <= cont_n;
         st_done <= done_n;
      end
   end

endmodule

// File: rtl/dma_chain_ptr.sv
module dma_chain_ptr
   import dma_chain_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int LEN_W      = 16,
   parameter int ALIGN_LOG2 = 5
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NPTR-1:0]             ptr_we,
   input  logic [DATA_W-1:0]           wdata,
   input  logic                        done_ok,
   input  logic                        reload,
   input  logic [LEN_W-1:0]            xfer_len,
   output logic [NPTR-1:0][DATA_W-1:0] ptr_q
);

   localparam int RW = LEN_W + 1;

   logic [RW-1:0]                len_rnd;
   logic [DATA_W-1:0]            len_ext;
   logic [NPTR-1:0][DATA_W-1:0]  ptr_n;

   if (ALIGN_LOG2 == 0) begin : g_no_align
      assign len_rnd = {1'b0, xfer_len};
   end else begin : g_align
      logic [RW-1:0] sum;
      assign sum     = {1'b0, xfer_len} + RW'((1 << ALIGN_LOG2) - 1);
      assign len_rnd = {sum[RW-1:ALIGN_LOG2], {ALIGN_LOG2{1'b0}}};
   end

   assign len_ext = DATA_W'(len_rnd);

   always_comb begin
      ptr_n = ptr_q;
      for (int i = 0; i < NPTR; i++) begin
         if (ptr_we[i]) ptr_n[i] = wdata;
      end
      if (done_ok) begin
         ptr_n[PI_SBASE]  = ptr_q[PI_BASE];
         ptr_n[PI_SLIMIT] = ptr_q[PI_BASE] + len_ext;
      end
      if (reload) begin
         ptr_n[PI_BASE]  = ptr_q[PI_CBASE];
         ptr_n[PI_LIMIT] = ptr_q[PI_CLIMIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ptr_q <= '0;
      else        ptr_q <= ptr_n;
   end

endmodule

// File: rtl/dma_chain_ctrl.sv
module dma_chain_ctrl
   import dma_chain_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 3,
   parameter int LEN_W      = 16,
   parameter int ALIGN_LOG2 = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              xfer_done,
   input  logic [LEN_W-1:0]  xfer_len,
   output logic              irq
);

   if (DATA_W < ST_DONE_BIT + 1) begin : g_chk_data_w
      $error("DATA_W too narrow for the control word");
   end
   if ((1 << ADDR_W) < NPTR + 1) begin : g_chk_addr_w
      $error("ADDR_W cannot reach every register");
   end
   if (LEN_W >= DATA_W || ALIGN_LOG2 >= LEN_W) begin : g_chk_len_w
      $error("LEN_W or ALIGN_LOG2 out of range");
   end

   cmd_t                        cmd;
   logic [NPTR-1:0]             ptr_we;
   logic [NPTR-1:0][DATA_W-1:0] ptr_q;
   logic                        st_en, st_cont, st_done;
   logic                        done_ok, reload;
   logic [DATA_W-1:0]           ctrl_word;

   dma_chain_decode #(.ADDR_W(ADDR_W)) u_dec (
      .bus_sel  (bus_sel),
      .bus_we   (bus_we),
      .bus_addr (bus_addr),
      .cmd_bits (bus_wdata[CMD_RST_BIT:CMD_EN_BIT]),
      .cmd      (cmd),
      .ptr_we   (ptr_we)
   );

   dma_chain_csr u_csr (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd       (cmd),
      .xfer_done (xfer_done),
      .st_en     (st_en),
      .st_cont   (st_cont),
      .st_done   (st_done),
      .done_ok   (done_ok),
      .reload    (reload)
   );

   dma_chain_ptr #(
      .DATA_W     (DATA_W),
      .LEN_W      (LEN_W),
      .ALIGN_LOG2 (ALIGN_LOG2)
   ) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .ptr_we   (ptr_we),
      .wdata    (bus_wdata),
      .done_ok  (done_ok),
      .reload   (reload),
      .xfer_len (xfer_len),
      .ptr_q    (ptr_q)
   );

   always_comb begin
      ctrl_word              = '0;
      ctrl_word[ST_EN_BIT]   = st_en;
      ctrl_word[ST_CONT_BIT] = st_cont;
      ctrl_word[ST_DONE_BIT] = st_done;
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(REG_CTRL)) bus_rdata = ctrl_word;
      for (int i = 0; i < NPTR; i++) begin
         if (bus_addr == ADDR_W'(i + 1)) bus_rdata = ptr_q[i];
      end
   end

   assign irq = st_done;

endmodule

// File: rtl/dma_chain_checker.sv
module dma_chain_checker
   import dma_chain_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        xfer_done,
   input logic                        irq,
   input logic                        st_en,
   input logic                        st_cont,
   input logic                        st_done,
   input cmd_t                        cmd,
   input logic [NPTR-1:0]             ptr_we,
   input logic [NPTR-1:0][DATA_W-1:0] ptr_q
);

   // R9: irq only rises after an accepted completion
   a_r9_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(xfer_done && st_en));

   // R9: irq only falls after a clear-complete or reset command
   a_r9_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> $past(cmd.clr_done || cmd.reset));

   // R4: reset command clears all status
   a_r4_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
      cmd.reset |=> (!st_en && !st_cont && !st_done && !irq));

   // R3: set-enable takes effect when no reset command competes
   a_r3_set_enable: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd.set_en && !cmd.reset) |=> st_en);

   // R5: direction bit alone leaves status untouched
   a_r5_dir_inert: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd.dir && !cmd.set_en && !cmd.set_cont && !cmd.clr_done && !cmd.reset && !xfer_done)
      |=> ($stable(st_en) && $stable(st_cont) && $stable(st_done)));

   // R7: saved base captures the base in use at completion
   a_r7_saved_base: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_done && st_en) |=> (ptr_q[PI_SBASE] == $past(ptr_q[PI_BASE])));

   // R8: chain reload swaps in the chain buffer
   a_r8_chain_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_done && st_en && st_cont)
      |=> (ptr_q[PI_BASE] == $past(ptr_q[PI_CBASE]) && ptr_q[PI_LIMIT] == $past(ptr_q[PI_CLIMIT])));

   // R8: continuation disarms after a reload unless re-armed
   a_r8_cont_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_done && st_en && st_cont && !cmd.set_cont) |=> !st_cont);

   // R6: disabled channel with no bus write holds its pointers and flag
   a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!st_en && ptr_we == '0) |=> ($stable(ptr_q) && $stable(st_done)));

endmodule

bind dma_chain_ctrl dma_chain_checker #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .xfer_done (xfer_done),
   .irq       (irq),
   .st_en     (st_en),
   .st_cont   (st_cont),
   .st_done   (st_done),
   .cmd       (cmd),
   .ptr_we    (ptr_we),
   .ptr_q     (ptr_q)
);

// File: tb/dma_chain_ctrl_test.sv
module dma_chain_ctrl_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_we = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        xfer_done = 1'b0;
   logic [15:0] xfer_len = '0;
   logic        irq;

   int checks = 0;
   int fails  = 0;

   // reference model state
   logic        m_en = 1'b0, m_cont = 1'b0, m_done = 1'b0;
   logic [31:0] m_ptr [6];

   always #4 clk = ~clk;

   dma_chain_ctrl uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .xfer_done(xfer_done), .xfer_len(xfer_len), .irq(irq)
   );

   function automatic logic [31:0] rup(input logic [15:0] l);
      logic [31:0] x;
      x = {16'b0, l} + 32'd31;
      return x & ~32'd31;
   endfunction

   function automatic logic [31:0] model_read(input logic [2:0] a);
      if (a == 3'd0) return {4'b0, m_done, 1'b0, m_cont, m_en, 24'b0};
      if (a == 3'd7) return 32'd0;
      return m_ptr[a - 3'd1];
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step(input logic wr, input logic [2:0] a, input logic [31:0] d,
                       input logic dn, input logic [15:0] ln);
      logic [31:0] np [6];
      logic csrw, de, ne, nc, nd;
      @(negedge clk);
      bus_sel = wr; bus_we = wr; bus_addr = a; bus_wdata = d;
      xfer_done = dn; xfer_len = ln;
      csrw = wr && (a == 3'd0);
      de   = dn && m_en;
      ne = (csrw && d[20]) ? 1'b0 : (csrw && d[16]) ? 1'b1 : m_en;
      nc = (csrw && d[20]) ? 1'b0 : (csrw && d[17]) ? 1'b1 : (de && m_cont) ? 1'b0 : m_cont;
      nd = (csrw && d[20]) ? 1'b0 : de ? 1'b1 : (csrw && d[19]) ? 1'b0 : m_done;
      np = m_ptr;
      for (int i = 0; i < 6; i++) if (wr && a == 3'(i + 1)) np[i] = d;
      if (de) begin
         np[2] = m_ptr[0];
         np[3] = m_ptr[0] + rup(ln);
         if (m_cont) begin
            np[0] = m_ptr[4];
            np[1] = m_ptr[5];
         end
      end
      @(posedge clk);
      #1;
      m_ptr = np; m_en = ne; m_cont = nc; m_done = nd;
   endtask

   task automatic rd(input string req, input logic [2:0] a);
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0; xfer_done = 1'b0; bus_addr = a;
      #1;
      chk(req, bus_rdata, model_read(a));
      chk({req, " irq"}, {31'b0, irq}, {31'b0, m_done});
   endtask

   task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
      step(1'b1, a, d, 1'b0, 16'd0);
   endtask

   task automatic done(input logic [15:0] l);
      step(1'b0, 3'd0, 32'd0, 1'b1, l);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      for (int i = 0; i < 6; i++) m_ptr[i] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1: reset state
      for (int a = 0; a < 8; a++) rd("R1 reset value", 3'(a));

      // R2: pointer programming and readback
      wr_reg(3'd1, 32'h0000_1000);
      wr_reg(3'd2, 32'h0000_2000);
      wr_reg(3'd5, 32'h0000_3000);
      wr_reg(3'd6, 32'h0000_4000);
      wr_reg(3'd3, 32'hDEAD_BEEF);
      rd("R2 base", 3'd1); rd("R2 chain limit", 3'd6); rd("R2 saved base", 3'd3);
      rd("R2 saved base reread", 3'd3);

      // R6: completion while disabled ignored
      done(16'd40);
      rd("R6 saved base hold", 3'd3); rd("R6 saved limit hold", 3'd4);

      // R3: set enable
      wr_reg(3'd0, 32'h0001_0000);
      rd("R3 enable bit24", 3'd0);
      chk("R3 ctrl literal", bus_rdata, 32'h0100_0000);

      // R5: direction bit alone inert
      wr_reg(3'd0, 32'h0004_0000);
      rd("R5 dir inert", 3'd0);

      // R7 / R9: completion without continuation
      done(16'd40);
      rd("R7 saved base", 3'd3);
      rd("R7 saved limit 40->64", 3'd4);
      chk("R7 saved limit literal", bus_rdata, 32'h0000_1040);
      rd("R8 base unchanged", 3'd1);
      rd("R9 complete bit27", 3'd0);

      // R8: armed continuation reloads and disarms
      wr_reg(3'd0, 32'h0002_0000);
      rd("R3 cont bit25", 3'd0);
      done(16'd64);
      rd("R7 aligned length", 3'd4);
      rd("R8 base from chain", 3'd1);
      chk("R8 base literal", bus_rdata, 32'h0000_3000);
      rd("R8 limit from chain", 3'd2);
      rd("R8 cont cleared", 3'd0);
      done(16'd1);
      rd("R7 length 1->32", 3'd4);
      chk("R7 len1 literal", bus_rdata, 32'h0000_3020);
      rd("R8 no reload when disarmed", 3'd1);
      done(16'd0);
      rd("R7 length 0", 3'd4);

      // R9: clear complete drops irq
      wr_reg(3'd0, 32'h0008_0000);
      rd("R9 irq cleared", 3'd0);
      chk("R9 irq literal", {31'b0, irq}, 32'd0);

      // R10 / R5: collisions with a completion
      wr_reg(3'd0, 32'h0002_0000);
      step(1'b1, 3'd1, 32'h0000_AAAA, 1'b1, 16'd32);
      rd("R10 reload beats bus write", 3'd1);
      step(1'b1, 3'd0, 32'h0008_0000, 1'b1, 16'd5);
      rd("R5 completion beats clear", 3'd0);
      step(1'b1, 3'd0, 32'h0002_0000, 1'b1, 16'd7);
      rd("R8 rearm same cycle", 3'd0);

      // R4: reset command wins over set bits
      step(1'b1, 3'd0, 32'h001F_0000, 1'b1, 16'd9);
      rd("R4 reset clears status", 3'd0);
      chk("R4 ctrl literal", bus_rdata, 32'd0);

      // constrained random mix
      for (int n = 0; n < 600; n++) begin
         logic [31:0] d;
         logic [2:0]  a;
         logic        w, dn;
         d  = $urandom;
         a  = 3'($urandom_range(0, 7));
         w  = ($urandom_range(0, 2) != 0);
         dn = ($urandom_range(0, 2) == 0);
         if (a == 3'd0 && $urandom_range(0, 7) != 0) d[20] = 1'b0;
         step(w, a, d, dn, 16'($urandom_range(0, 1600)));
         rd("R2 R7 R8 random readback", 3'($urandom_range(0, 7)));
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule